// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address into a physical address by reading a page table held in on-chip registers. The upper bits of the virtual address form the virtual page number. This number selects one table entry directly, so no tag is stored or compared. The low bits are the in-page offset and pass through unchanged. Each entry holds a valid flag, a physical page number, a use flag and a dirty flag. A lookup that selects an invalid entry returns a page fault and no address.

A successful lookup sets the entry's use flag. A successful lookup with write intent also sets its dirty flag. A one-cycle strobe clears every use flag at once. Replacement software can ask the block for a victim. The block picks a valid entry whose use flag is clear, starting a circular scan at a pseudo-random index. It reports the entry's dirty flag with it, so the caller knows whether the page must be written back. A separate write port loads an entry's valid flag and physical page number, and this also clears the entry's use and dirty flags.

Top module: `pt_xlate`

## Requirements
- R1: The virtual page number is bits [VA_W-1:OFF_W] of the virtual address. The physical address of a hit is {physical page number, virtual address bits [OFF_W-1:0]}. With the defaults, address 0x08CAA through an entry 2 mapped to page 2 gives 0x08CAA.
- R2: A request sampled at a clock edge produces `rsp_valid_o` high for exactly the following cycle, together with its fault flag and address.
- R3: After reset, every entry is invalid, with its use and dirty flags clear. `rsp_valid_o` and `vic_ack_o` are low.
- R4: A request that selects an invalid entry returns `rsp_fault_o`=1 and `rsp_paddr_o`=0.
- R5: A successful lookup sets the selected entry's use flag. A fault changes no flag.
- R6: A successful lookup with `req_write_i`=1 sets the entry's dirty flag. A read leaves the flag unchanged.
- R7: `clr_use_i` clears all use flags in a single cycle. A successful lookup in that same cycle still leaves its own entry's use flag set.
- R8: An entry write loads the valid flag and the physical page number and clears the use and dirty flags. Lookups see the new contents from the next cycle onward.
- R9: A victim request sampled at an edge produces `vic_ack_o` in the next cycle. If any valid entry has a clear use flag, `vic_vpn_o` is one of those entries, and `vic_dirty_o` is that entry's dirty flag.
- R10: If every valid entry has its use flag set, the victim is any valid entry. If no entry is valid, `vic_found_o`=0, `vic_vpn_o`=0 and `vic_dirty_o`=0.
- R11: The scan starts at an index taken from a free-running maximal-length 8-bit LFSR. When the request is held for 256 consecutive cycles with fixed table contents, every eligible entry is returned at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| req_write_i | input | 1 | Request has write intent |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_fault_o | output | 1 | Page fault: entry not valid |
| rsp_paddr_o | output | PPN_W+OFF_W | Physical address; zero on fault |
| wr_en_i | input | 1 | Entry write strobe |
| wr_vpn_i | input | VA_W-OFF_W | Entry to write |
| wr_valid_i | input | 1 | Valid flag to load |
| wr_ppn_i | input | PPN_W | Physical page number to load |
| clr_use_i | input | 1 | Clear every use flag |
| vic_req_i | input | 1 | Victim selection request |
| vic_ack_o | output | 1 | Victim result present this cycle |
| vic_found_o | output | 1 | At least one valid entry existed |
| vic_vpn_o | output | VA_W-OFF_W | Selected victim page |
| vic_dirty_o | output | 1 | Selected victim is dirty |

## Verification
The bench builds the block with its defaults: 20-bit virtual addresses, 14-bit offsets and 4-bit physical page numbers, which gives a 64-entry table. This is small enough that a bench-side model of every flag can predict the eligible victim set exactly. It can also shrink that set to a single entry, so the expected victim is fixed. An 8-bit LFSR has a period of 255 cycles. Holding the victim request for one full period therefore covers every start index, which makes the claim that each eligible entry is reachable testable in a deterministic way.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned PT_VA_W   = 20;
  localparam int unsigned PT_OFF_W  = 14;
  localparam int unsigned PT_PPN_W  = 4;
  localparam int unsigned PT_LFSR_W = 8;
  localparam logic [7:0]  PT_TAPS   = 8'hB8;  // x^8+x^6+x^5+x^4+1, Galois form
endpackage

// File: rtl/pt_lfsr.sv
module pt_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter int unsigned OUT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= W'(1);
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else state_q <= state_q >> 1;
  end

  // fold every state bit into the output so all states reach all indices
  always_comb begin
    rnd_o = '0;
    for (int i = 0; i < W; i++) rnd_o[i % OUT_W] = rnd_o[i % OUT_W] ^ state_q[i];
  end
endmodule

// File: rtl/pt_store.sv
module pt_store #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned PPN_W = 4,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic                      wr_valid_i,
  input  logic [PPN_W-1:0]          wr_ppn_i,
  input  logic                      acc_en_i,
  input  logic [IDX_W-1:0]          acc_idx_i,
  input  logic                      acc_write_i,
  input  logic                      clr_use_i,
  output logic [N-1:0]              valid_o,
  output logic [N-1:0]              used_o,
  output logic [N-1:0]              dirty_o,
  output logic [N-1:0][PPN_W-1:0]   ppn_o
);
  logic [N-1:0]            valid_q, used_q, dirty_q;
  logic [N-1:0][PPN_W-1:0] ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      used_q  <= '0;
      dirty_q <= '0;
      ppn_q   <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
          valid_q[i] <= wr_valid_i;
          ppn_q[i]   <= wr_ppn_i;
          used_q[i]  <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else begin
          if (clr_use_i) used_q[i] <= 1'b0;
          // access set wins over the bulk clear
          if (acc_en_i && acc_idx_i == IDX_W'(i)) begin
            used_q[i] <= 1'b1;
            if (acc_write_i) dirty_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign used_o  = used_q;
  assign dirty_o = dirty_q;
  assign ppn_o   = ppn_q;
endmodule

// File: rtl/pt_pick.sv
module pt_pick #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic [N-1:0]     cand_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] j;

  // circular scan beginning at start_i, first candidate wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    j       = '0;
    for (int k = 0; k < N; k++) begin
      j = start_i + IDX_W'(k);
      if (!found_o && cand_i[j]) begin
        found_o = 1'b1;
        idx_o   = j;
      end
    end
  end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_pkg::*;
#(
  parameter int unsigned VA_W   = PT_VA_W,
  parameter int unsigned OFF_W  = PT_OFF_W,
  parameter int unsigned PPN_W  = PT_PPN_W,
  parameter int unsigned LFSR_W = PT_LFSR_W,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned N     = 1 << VPN_W,
  localparam int unsigned PA_W  = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic             wr_valid_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             clr_use_i,
  input  logic             vic_req_i,
  output logic             vic_ack_o,
  output logic             vic_found_o,
  output logic [VPN_W-1:0] vic_vpn_o,
  output logic             vic_dirty_o
);
  logic [VPN_W-1:0]        vpn;
  logic [OFF_W-1:0]        off;
  logic [N-1:0]            valid, used, dirty;
  logic [N-1:0][PPN_W-1:0] ppn;
  logic                    hit;
  logic [N-1:0]            idle, pick_mask;
  logic [VPN_W-1:0]        start, pick_idx;
  logic                    pick_found;

  assign vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign off = req_vaddr_i[OFF_W-1:0];
  assign hit = valid[vpn];

  pt_store #(.IDX_W(VPN_W), .PPN_W(PPN_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_vpn_i),
    .wr_valid_i (wr_valid_i),
    .wr_ppn_i   (wr_ppn_i),
    .acc_en_i   (req_valid_i && hit),
    .acc_idx_i  (vpn),
    .acc_write_i(req_write_i),
    .clr_use_i  (clr_use_i),
    .valid_o    (valid),
    .used_o     (used),
    .dirty_o    (dirty),
    .ppn_o      (ppn)
  );

  pt_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(PT_TAPS)), .OUT_W(VPN_W)) i_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (start)
  );

  assign idle      = valid & ~used;
  assign pick_mask = (|idle) ? idle : valid;

  pt_pick #(.IDX_W(VPN_W)) i_pick (
    .cand_i (pick_mask),
    .start_i(start),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_fault_o <= !hit;
        rsp_paddr_o <= hit ? {ppn[vpn], off} : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vic_ack_o   <= 1'b0;
      vic_found_o <= 1'b0;
      vic_vpn_o   <= '0;
      vic_dirty_o <= 1'b0;
    end else begin
      vic_ack_o <= vic_req_i;
      if (vic_req_i) begin
        vic_found_o <= pick_found;
        vic_vpn_o   <= pick_found ? pick_idx : '0;
        vic_dirty_o <= pick_found && dirty[pick_idx];
      end
    end
  end
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PA_W  = 18,
  parameter int unsigned VPN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [OFF_W-1:0] req_off_i,
  input logic             vic_req_i,
  input logic             rsp_valid_o,
  input logic             rsp_fault_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             vic_ack_o,
  input logic             vic_found_o,
  input logic [VPN_W-1:0] vic_vpn_o,
  input logic             vic_dirty_o
);
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_fault_o || rsp_paddr_o[OFF_W-1:0] == $past(req_off_i))); // R1
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_RSP_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> rsp_paddr_o == '0); // R4
  AST_VIC_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_req_i |=> vic_ack_o); // R9
  AST_VIC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_ack_o && !vic_found_o) |-> (vic_vpn_o == '0 && !vic_dirty_o)); // R10
endmodule

bind pt_xlate pt_xlate_chk #(.OFF_W(OFF_W), .PA_W(PA_W), .VPN_W(VPN_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_off_i  (req_vaddr_i[OFF_W-1:0]),
  .vic_req_i  (vic_req_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_fault_o(rsp_fault_o),
  .rsp_paddr_o(rsp_paddr_o),
  .vic_ack_o  (vic_ack_o),
  .vic_found_o(vic_found_o),
  .vic_vpn_o  (vic_vpn_o),
  .vic_dirty_o(vic_dirty_o)
);

// File: tb/test_pt_xlate.sv
`timescale 1ns/1ps
module test_pt_xlate;
  localparam int VPN_W = 6;
  localparam int N     = 64;
  localparam int NVEC  = 8;

  // {vaddr[19:0], write, exp_fault, exp_paddr[17:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {20'h08CAA, 1'b0, 1'b0, 18'h08CAA},
    {20'h193C0, 1'b0, 1'b1, 18'h00000},
    {20'h00000, 1'b1, 1'b0, 18'h24000},
    {20'h1FFFF, 1'b0, 1'b0, 18'h07FFF},
    {20'h13ABC, 1'b1, 1'b0, 18'h2FABC},
    {20'h16001, 1'b0, 1'b0, 18'h2A001},
    {20'h04123, 1'b0, 1'b1, 18'h00000},
    {20'hFC000, 1'b1, 1'b1, 18'h00000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_vaddr = '0;
  logic rsp_valid, rsp_fault;
  logic [17:0] rsp_paddr;
  logic wr_en = 1'b0, wr_valid = 1'b0;
  logic [5:0] wr_vpn = '0;
  logic [3:0] wr_ppn = '0;
  logic clr_use = 1'b0, vic_req = 1'b0;
  logic vic_ack, vic_found, vic_dirty;
  logic [5:0] vic_vpn;

  bit m_valid [N], m_used [N], m_dirty [N];
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pt_xlate i_pt_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .wr_en_i(wr_en), .wr_vpn_i(wr_vpn), .wr_valid_i(wr_valid), .wr_ppn_i(wr_ppn),
    .clr_use_i(clr_use), .vic_req_i(vic_req),
    .vic_ack_o(vic_ack), .vic_found_o(vic_found), .vic_vpn_o(vic_vpn), .vic_dirty_o(vic_dirty)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic program_entry(input int vpn, input bit v, input logic [3:0] ppn);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_vpn = 6'(vpn); wr_valid = v; wr_ppn = ppn;
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_valid[vpn] = v; m_used[vpn] = 1'b0; m_dirty[vpn] = 1'b0;
  endtask

  task automatic translate(input logic [19:0] va, input bit w, input bit clr,
                           input string req, input bit exp_fault, input logic [17:0] exp_pa);
    int vpn;
    vpn = int'(va[19:14]);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va; req_write = w; clr_use = clr;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; clr_use = 1'b0;
    chk({req, " rsp_valid R2"}, 32'(rsp_valid), 32'd1);
    chk({req, " fault"}, 32'(rsp_fault), 32'(exp_fault));
    chk({req, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
    if (clr) for (int i = 0; i < N; i++) m_used[i] = 1'b0;
    if (m_valid[vpn]) begin
      m_used[vpn] = 1'b1;
      if (w) m_dirty[vpn] = 1'b1;
    end
  endtask

  // checks the current victim outputs against the model
  task automatic judge_victim(input string req);
    bit any_idle, any_valid;
    int v;
    any_idle = 1'b0; any_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && !m_used[i]) any_idle = 1'b1;
      if (m_valid[i]) any_valid = 1'b1;
    end
    v = int'(vic_vpn);
    chk({req, " vic_ack R9"}, 32'(vic_ack), 32'd1);
    chk({req, " vic_found R10"}, 32'(vic_found), 32'(any_valid));
    if (any_idle)
      chk({req, " idle victim R9"}, 32'(m_valid[v] && !m_used[v]), 32'd1);
    else if (any_valid)
      chk({req, " fallback victim R10"}, 32'(m_valid[v]), 32'd1);
    else
      chk({req, " empty vpn R10"}, 32'(vic_vpn), 32'd0);
    chk({req, " vic_dirty R9"}, 32'(vic_dirty), 32'(any_valid && m_dirty[v]));
  endtask

  task automatic victim_once(input string req);
    @(posedge clk); #1; vic_req = 1'b1;
    @(posedge clk); #1; vic_req = 1'b0;
    judge_victim(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit seen [N];
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_used[i] = 0; m_dirty[i] = 0; seen[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("reset rsp_valid R3", 32'(rsp_valid), 32'd0);
    chk("reset vic_ack R3", 32'(vic_ack), 32'd0);
    rst_n = 1'b1;
    translate(20'h08CAA, 1'b0, 1'b0, "R3 reset entries invalid", 1'b1, 18'h0);
    victim_once("R10 empty after reset");

    program_entry(0, 1, 4'h9);
    program_entry(2, 1, 4'h2);
    program_entry(4, 1, 4'hB);
    program_entry(5, 1, 4'hA);
    program_entry(7, 1, 4'h1);

    for (int k = 0; k < NVEC; k++)
      translate(VEC[k][39:20], VEC[k][19], 1'b0, "R1 R4 vector", VEC[k][18], VEC[k][17:0]);

    @(posedge clk); #1;
    chk("R2 rsp_valid single cycle", 32'(rsp_valid), 32'd0);

    // all valid entries now used: fallback
    victim_once("R10 fallback");

    // R7: clear with same-cycle access of vpn 2
    translate(20'h08000, 1'b0, 1'b1, "R7 clear plus access", 1'b0, 18'h08000);

    // R11: hold request one LFSR period, candidates {0,4,5,7}
    @(posedge clk); #1; vic_req = 1'b1;
    for (int c = 0; c < 256; c++) begin
      @(posedge clk); #1;
      judge_victim("R11 stream");
      seen[vic_vpn] = 1'b1;
    end
    vic_req = 1'b0;
    chk("R11 reach vpn0", 32'(seen[0]), 32'd1);
    chk("R11 reach vpn4", 32'(seen[4]), 32'd1);
    chk("R11 reach vpn5", 32'(seen[5]), 32'd1);
    chk("R11 reach vpn7", 32'(seen[7]), 32'd1);
    chk("R7 vpn2 kept in use", 32'(seen[2]), 32'd0);

    // R5/R6: use bits narrow the set to vpn 7, read-only so clean
    translate(20'h00010, 1'b0, 1'b0, "R5 access vpn0", 1'b0, 18'h24010);
    translate(20'h10000, 1'b0, 1'b0, "R5 access vpn4", 1'b0, 18'h2C000);
    translate(20'h14000, 1'b0, 1'b0, "R5 access vpn5", 1'b0, 18'h28000);
    translate(20'h04000, 1'b0, 1'b0, "R5 fault vpn1", 1'b1, 18'h0);
    victim_once("R9 single candidate");
    chk("R9 single candidate vpn", 32'(vic_vpn), 32'd7);
    chk("R6 read leaves clean", 32'(vic_dirty), 32'd0);

    // R6: write vpn 7, then make it the only idle entry again
    translate(20'h1C000, 1'b1, 1'b0, "R6 write vpn7", 1'b0, 18'h04000);
    translate(20'h00000, 1'b0, 1'b1, "R7 clear via vpn0", 1'b0, 18'h24000);
    translate(20'h08000, 1'b0, 1'b0, "R5 access vpn2", 1'b0, 18'h08000);
    translate(20'h10000, 1'b0, 1'b0, "R5 access vpn4", 1'b0, 18'h2C000);
    translate(20'h14000, 1'b0, 1'b0, "R5 access vpn5", 1'b0, 18'h28000);
    victim_once("R6 dirty victim");
    chk("R6 victim vpn", 32'(vic_vpn), 32'd7);
    chk("R6 victim dirty", 32'(vic_dirty), 32'd1);

    // R8: rewrite dirty vpn 4, it becomes the only idle entry and clean
    translate(20'h1C000, 1'b0, 1'b0, "R5 access vpn7", 1'b0, 18'h04000);
    program_entry(4, 1, 4'h3);
    victim_once("R8 rewritten entry");
    chk("R8 victim vpn", 32'(vic_vpn), 32'd4);
    chk("R8 dirty cleared", 32'(vic_dirty), 32'd0);
    translate(20'h13ABC, 1'b1, 1'b0, "R8 new mapping", 1'b0, 18'h0FABC);

    // R10: empty table again
    program_entry(0, 0, 4'h0);
    program_entry(2, 0, 4'h0);
    program_entry(4, 0, 4'h0);
    program_entry(5, 0, 4'h0);
    program_entry(7, 0, 4'h0);
    translate(20'h08CAA, 1'b0, 1'b0, "R8 invalidated", 1'b1, 18'h0);
    victim_once("R10 empty table");
    chk("R10 found low", 32'(vic_found), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule